// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block follows every instruction through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction carries a fault record. The record moves down the pipeline together with the instruction. A fault seen at a stage is posted into the record of the instruction that occupies that stage in that cycle. From that cycle on, the block withdraws write permission from that instruction and from every younger instruction.

Faults are acted on only at writeback. The exception taken is therefore always the one belonging to the oldest faulting instruction in program order, even when a younger instruction found its fault in an earlier cycle. When an exception is taken, the block does four things:
- It flushes the four earlier stages.
- It saves the program counter of the faulting instruction for a later restart.
- It latches a cause code.
- It asks fetch to insert a trap instruction.

New instructions enter through a valid/ready handshake. The block holds `in_ready` high in every cycle except the cycle in which an exception is taken. In that cycle an offered instruction is not accepted, and the source must hold or withdraw it. All other pins are plain control and status signals with no handshake.

Top module: `exc_track_pipe`

## Requirements
- R1: After reset, `wr_en` is all zero, `trap_req` is 0, `epc` is 0, `cause` is 0 and `in_ready` is 1.
- R2: An instruction is accepted at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only in the cycle an exception is taken, and an instruction offered in that cycle is dropped.
- R3: An accepted instruction occupies fetch in the cycle after acceptance and then one further stage per cycle. While it has no fault, `wr_en[s]` is high when it is in stage s (bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback).
- R4: Fault pins apply to the instruction in their stage during the current cycle. `flt_fetch` and `flt_mem` use bit 0 for a page fault, bit 1 for a misaligned access and bit 2 for a protection violation. A posted fault clears `wr_en` for that instruction in its current stage and in every later stage.
- R5: `wr_en[s]` is low whenever any instruction in stage s or in an older (higher-numbered) stage carries a fault.
- R6: Exceptions are taken at writeback, in program order. When two instructions both fault, the older one is taken, whatever the detection order.
- R7: In the cycle an exception is taken, all four earlier stages are emptied. `trap_req` is high for exactly the following cycle. No instruction younger than the faulting one ever writes.
- R8: When `trap_req` is high, `epc` holds the PC of the faulting instruction. `epc` and `cause` keep their values until the next exception is taken.
- R9: The cause codes are:
  - 1: fetch page fault
  - 2: fetch misaligned access
  - 3: fetch protection violation
  - 4: illegal opcode
  - 5: arithmetic overflow
  - 6: data page fault
  - 7: data misaligned access
  - 8: data protection violation

  When one instruction carries several faults, the lowest code is reported.
- R10: While `ovf_en` is 0, `flt_exec_ovf` neither posts a fault nor removes write permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_ready | output | 1 | The offered instruction is accepted at the next edge |
| in_pc | input | PC_W | PC of the offered instruction |
| ovf_en | input | 1 | Arithmetic overflow is reported when high |
| flt_fetch | input | 3 | Fetch-stage faults: page, misaligned, protection |
| flt_decode | input | 1 | Illegal opcode at decode |
| flt_exec_ovf | input | 1 | Arithmetic overflow at execute |
| flt_mem | input | 3 | Memory-stage faults: page, misaligned, protection |
| wr_en | output | 5 | Write permission per stage, bit 0 fetch through bit 4 writeback |
| trap_req | output | 1 | One-cycle request to insert a trap at fetch |
| epc | output | PC_W | Saved PC of the faulting instruction |
| cause | output | 4 | Cause code of the last exception taken |

## Verification
The hardest case to reach from the ports is an inversion of detection order. A younger instruction flags a fault in a cycle before its older neighbour flags its own, and only the older one may be taken. The stimulus places a data page fault on the first instruction, which is detected at memory, and a fetch fault on the second, which is detected two cycles earlier. The bench then expects the trap to name the first PC. The bench also tracks every instruction's stage from its acceptance cycle and predicts all five write enables in every cycle. This prediction covers the cycles in which a fault is present but not yet taken.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // pipeline depth and fault record layout
  localparam int NSTG   = 5;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 4;

  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;
  localparam int ST_WB  = 4;

  // record bit positions; ascending order is report priority
  localparam int B_IF_LO  = 0;   // three fetch faults at bits 0..2
  localparam int B_ILL    = 3;
  localparam int B_OVF    = 4;
  localparam int B_MEM_LO = 5;   // three data faults at bits 5..7

  typedef enum logic [CODE_W-1:0] {
    CZ_NONE     = 4'd0,
    CZ_IF_PAGE  = 4'd1,
    CZ_IF_ALIGN = 4'd2,
    CZ_IF_PROT  = 4'd3,
    CZ_ILLEGAL  = 4'd4,
    CZ_OVERFLOW = 4'd5,
    CZ_DM_PAGE  = 4'd6,
    CZ_DM_ALIGN = 4'd7,
    CZ_DM_PROT  = 4'd8
  } cause_e;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg #(
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [PC_W-1:0]  ld_pc,
  input  logic [VEC_W-1:0] ld_vec,
  output logic             q_valid,
  output logic [PC_W-1:0]  q_pc,
  output logic [VEC_W-1:0] q_vec
);
  // one pipeline slot: occupancy, PC and accumulated fault record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_vec   <= '0;
    end else begin
      q_valid <= ld_valid;
      q_pc    <= ld_pc;
      q_vec   <= ld_valid ? ld_vec : '0;
    end
  end
endmodule

// File: rtl/exc_wr_gate.sv
module exc_wr_gate #(
  parameter int NSTG  = 5,
  parameter int VEC_W = 8
) (
  input  logic [NSTG-1:0]            stg_valid,
  input  logic [NSTG-1:0][VEC_W-1:0] eff_vec,
  output logic [NSTG-1:0]            we
);
  // blocked[s]: a fault exists in stage s or any older stage
  logic [NSTG-1:0] blocked;

  for (genvar s = 0; s < NSTG; s++) begin : g_gate
    if (s == NSTG - 1) begin : g_top
      assign blocked[s] = stg_valid[s] & (|eff_vec[s]);
    end else begin : g_rest
      assign blocked[s] = (stg_valid[s] & (|eff_vec[s])) | blocked[s+1];
    end
    assign we[s] = stg_valid[s] & ~blocked[s];
  end
endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc #(
  parameter int VEC_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic [VEC_W-1:0]  vec,
  output logic [CODE_W-1:0] code
);
  // lowest set bit wins: earliest stage, then page < align < protection
  always_comb begin
    code = '0;
    for (int b = VEC_W - 1; b >= 0; b--) begin
      if (vec[b]) code = CODE_W'(b + 1);
    end
  end
endmodule

// File: rtl/exc_track_pipe.sv
module exc_track_pipe
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              ovf_en,
  input  logic [2:0]        flt_fetch,
  input  logic              flt_decode,
  input  logic              flt_exec_ovf,
  input  logic [2:0]        flt_mem,
  output logic [NSTG-1:0]   wr_en,
  output logic              trap_req,
  output logic [PC_W-1:0]   epc,
  output logic [CODE_W-1:0] cause
);
  logic [NSTG-1:0]            stg_v;
  logic [NSTG-1:0][PC_W-1:0]  stg_pc;
  logic [NSTG-1:0][VEC_W-1:0] stg_vec;
  logic [NSTG-1:0][VEC_W-1:0] post;
  logic [NSTG-1:0][VEC_W-1:0] eff;
  logic [NSTG-1:0]            ld_v;
  logic [NSTG-1:0][PC_W-1:0]  ld_pc;
  logic [NSTG-1:0][VEC_W-1:0] ld_vec;
  logic                       take;
  logic [CODE_W-1:0]          wb_code;

  // faults detected this cycle, placed at their record positions
  always_comb begin
    post = '0;
    post[ST_IF][B_IF_LO +: 3]   = flt_fetch;
    post[ST_ID][B_ILL]          = flt_decode;
    post[ST_EX][B_OVF]          = flt_exec_ovf & ovf_en;
    post[ST_MEM][B_MEM_LO +: 3] = flt_mem;
  end

  // exception is taken when a faulted instruction sits in writeback
  assign take     = stg_v[ST_WB] & (|stg_vec[ST_WB]);
  assign in_ready = ~take;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    assign eff[s] = stg_vec[s] | (post[s] & {VEC_W{stg_v[s]}});

    if (s == 0) begin : g_entry
      assign ld_v[s]   = in_valid & in_ready;
      assign ld_pc[s]  = in_pc;
      assign ld_vec[s] = '0;
    end else begin : g_chain
      assign ld_v[s]   = stg_v[s-1] & ~take;
      assign ld_pc[s]  = stg_pc[s-1];
      assign ld_vec[s] = eff[s-1];
    end

    exc_stage_reg #(.PC_W(PC_W), .VEC_W(VEC_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_v[s]),
      .ld_pc    (ld_pc[s]),
      .ld_vec   (ld_vec[s]),
      .q_valid  (stg_v[s]),
      .q_pc     (stg_pc[s]),
      .q_vec    (stg_vec[s])
    );
  end

  exc_wr_gate #(.NSTG(NSTG), .VEC_W(VEC_W)) u_gate (
    .stg_valid (stg_v),
    .eff_vec   (eff),
    .we        (wr_en)
  );

  exc_cause_enc #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_enc (
    .vec  (stg_vec[ST_WB]),
    .code (wb_code)
  );

  // trap request, saved PC and cause
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      epc      <= '0;
      cause    <= '0;
    end else begin
      trap_req <= take;
      if (take) begin
        epc   <= stg_pc[ST_WB];
        cause <= wb_code;
      end
    end
  end

  AST_WB_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[ST_WB] |-> (stg_vec[ST_WB] == '0)); // R4
  AST_YOUNGER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (wr_en[NSTG-2:0] == '0)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (stg_v == '0)); // R7
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req); // R7
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> ($stable(epc) && $stable(cause))); // R8
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (cause != '0 && cause <= CODE_W'(VEC_W))); // R9
endmodule

// File: tb/exc_track_pipe_test.sv
module exc_track_pipe_test;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [PC_W-1:0] in_pc = '0;
  logic            ovf_en = 1'b1;
  logic [2:0]      flt_fetch = '0;
  logic            flt_decode = 1'b0;
  logic            flt_exec_ovf = 1'b0;
  logic [2:0]      flt_mem = '0;
  logic [4:0]      wr_en;
  logic            trap_req;
  logic [PC_W-1:0] epc;
  logic [3:0]      cause;

  always #10 clk = ~clk;

  exc_track_pipe #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .ovf_en(ovf_en), .flt_fetch(flt_fetch),
    .flt_decode(flt_decode), .flt_exec_ovf(flt_exec_ovf), .flt_mem(flt_mem),
    .wr_en(wr_en), .trap_req(trap_req), .epc(epc), .cause(cause)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  typedef struct { bit is_trap; logic [PC_W-1:0] pc; logic [3:0] code; } exp_t;
  exp_t sb[$];

  bit [2:0] p_if [8];
  bit       p_id [8];
  bit       p_ex [8];
  bit [2:0] p_mem[8];
  bit       cur_en;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 8; i++) begin
      p_if[i] = '0; p_id[i] = 1'b0; p_ex[i] = 1'b0; p_mem[i] = '0;
    end
  endtask

  // faults an instruction has accumulated by the end of stage t (R4, R9, R10)
  function automatic logic [7:0] seen(input int k, input int t);
    logic [7:0] v = '0;
    if (t >= 0) v[2:0] = p_if[k];
    if (t >= 1) v[3]   = p_id[k];
    if (t >= 2) v[4]   = p_ex[k] & cur_en;
    if (t >= 3) v[7:5] = p_mem[k];
    return v;
  endfunction

  function automatic bit live(input int j, input int it, input int n, input int f);
    if (j < 0 || j >= n) return 1'b0;
    if (f >= 0 && (j >= f + 5 || it > f + 5)) return 1'b0;
    return 1'b1;
  endfunction

  // monitor: pops expected retirements and traps as the design produces them
  always @(negedge clk) begin
    #8;
    if (mon_on) begin
      if (wr_en[4]) begin
        if (sb.size() == 0 || sb[0].is_trap) check(1'b0, "R6 unexpected writeback write", 1, 0);
        else begin void'(sb.pop_front()); check(1'b1, "R3", 1, 1); end
      end
      if (trap_req) begin
        if (sb.size() == 0 || !sb[0].is_trap) check(1'b0, "R7 unexpected trap_req", 1, 0);
        else begin
          check(epc == sb[0].pc, "R8 epc", epc, sb[0].pc);
          check(cause == sb[0].code, "R9 cause", cause, sb[0].code);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic run_batch(input int n, input bit en, input logic [31:0] base, input string tag);
    int f = -1;
    int tk;
    int last;
    logic [7:0] fv;
    cur_en = en;
    ovf_en = en;
    for (int j = 0; j < n; j++) if (f < 0 && seen(j, 4) != '0) f = j;
    for (int j = 0; j < ((f < 0) ? n : f); j++) sb.push_back('{1'b0, '0, '0});
    if (f >= 0) begin
      fv = seen(f, 4);
      for (int b = 7; b >= 0; b--) if (fv[b]) tk = b + 1;
      sb.push_back('{1'b1, base + 32'(4 * f), 4'(tk)});
    end
    tk = (f >= 0) ? f + 5 : -100;
    last = (f >= 0) ? tk + 3 : n + 6;
    for (int it = 0; it <= last; it++) begin
      @(negedge clk);
      in_valid = (it < n);
      in_pc = base + 32'(4 * it);
      flt_fetch = '0; flt_decode = 1'b0; flt_exec_ovf = 1'b0; flt_mem = '0;
      for (int s = 0; s < 4; s++) begin
        int j = it - s - 1;
        if (live(j, it, n, f)) begin
          if (s == 0) flt_fetch = p_if[j];
          if (s == 1) flt_decode = p_id[j];
          if (s == 2) flt_exec_ovf = p_ex[j];
          if (s == 3) flt_mem = p_mem[j];
        end
      end
      #8;
      check(in_ready == !(it == tk), {tag, " R2 in_ready"}, in_ready, !(it == tk));
      for (int s = 0; s < 5; s++) begin
        bit e = live(it - s - 1, it, n, f);
        for (int t = s; t < 5; t++)
          if (live(it - t - 1, it, n, f) && seen(it - t - 1, t) != '0) e = 1'b0;
        // R3 R4 R5 R7: predicted write permission per stage
        check(wr_en[s] == e, $sformatf("%s R5 wr_en[%0d] cycle %0d", tag, s, it), wr_en[s], e);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #8;
    check(sb.size() == 0, {tag, " R6 scoreboard drained"}, sb.size(), 0);
    sb.delete();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [31:0] hold_pc;
    logic [3:0]  hold_cz;
    clear_plan();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #8;
    check(wr_en == '0, "R1 wr_en", wr_en, 0);
    check(trap_req == 1'b0, "R1 trap_req", trap_req, 0);
    check(epc == '0, "R1 epc", epc, 0);
    check(cause == '0, "R1 cause", cause, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    mon_on = 1'b1;

    clear_plan();                       // R3 clean stream
    run_batch(4, 1'b1, 32'h1000, "clean");
    clear_plan(); p_id[1] = 1'b1;       // R4 illegal opcode, code 4
    run_batch(3, 1'b1, 32'h2000, "illegal");
    clear_plan(); p_mem[0] = 3'b001; p_if[1] = 3'b001; // R6 older data fault wins
    run_batch(2, 1'b1, 32'h3000, "order");
    clear_plan(); p_if[0] = 3'b010; p_ex[0] = 1'b1; p_mem[0] = 3'b100; // R9 priority
    run_batch(1, 1'b1, 32'h4000, "prio");
    hold_pc = epc; hold_cz = cause;
    clear_plan(); p_ex[0] = 1'b1;       // R10 masked overflow retires
    run_batch(2, 1'b0, 32'h5000, "masked");
    check(epc == hold_pc, "R8 epc held", epc, hold_pc);
    check(cause == hold_cz, "R8 cause held", cause, hold_cz);
    clear_plan(); p_ex[0] = 1'b1;       // R10 enabled overflow, code 5
    run_batch(2, 1'b1, 32'h6000, "ovf");
    clear_plan(); p_if[0] = 3'b100;     // R7 R2 flush with offer in take cycle
    run_batch(6, 1'b1, 32'h7000, "flush");
    clear_plan(); p_mem[2] = 3'b010;    // R9 data misaligned, code 7
    run_batch(3, 1'b1, 32'h8000, "dalign");
    clear_plan(); p_mem[0] = 3'b100;    // R9 data protection, code 8
    run_batch(2, 1'b1, 32'h9000, "dprot");
    clear_plan(); p_if[0] = 3'b001;     // R9 fetch page fault, code 1
    run_batch(2, 1'b1, 32'hA000, "ipage");
    finish_run();
  end
endmodule